// File: doc/BRIEF.md
# Masked 2D SIMD Row Controller

This block sends one broadcast operation per clock to a grid of accumulating elements. The grid has 8 rows of 64 elements. Each element holds a signed 32-bit accumulator. An operation reaches an element only when two things hold: the element's row is enabled in the row-mask register, and the element's own mask bit is set. All other elements keep their contents. Software can disable whole rows with one write, or shape an irregular active set one row of bits at a time.

The block also contains a reduction unit. It adds up the 64 accumulators of one chosen row and returns a 40-bit signed total. The total arrives a fixed two cycles after the request and comes with a one-cycle valid pulse. A reduction request may share a cycle with a broadcast operation. In that case the total reflects the accumulator values from before that operation. The reduction reads the row whatever the masks say.

Top module: `rowsimd_ctrl`

## Requirements
- R1: After reset the row-mask register reads all ones, every element mask bit is set, and every accumulator holds zero.
- R2: `op_code` selects the broadcast operation: 0 does nothing; 1 clears the accumulator; 2 loads `op_imm`; 3 adds `op_imm` with 32-bit wraparound; 4 adds the signed product of `op_imm[7:0]` and `op_imm[15:8]`. Codes 5, 6 and 7 change nothing.
- R3: When `rmask_we` is high, `rmask_wdata` is written to the row-mask register and appears on `row_mask` from the next cycle. Bit r enables row r.
- R4: When `emask_we` is high, `emask_wdata` replaces the element mask bits of row `emask_row`. Bit c belongs to column c.
- R5: An element updates only if its row-mask bit and its own mask bit are both 1. Every other accumulator keeps its value.
- R6: A mask write affects operations from the following cycle on. An operation issued in the same cycle as the write still uses the old masks.
- R7: A reduction returns the exact signed sum of the 64 accumulators of row `red_row` as a 40-bit value, including when every term is at the 32-bit extreme. It ignores both mask levels.
- R8: `red_valid` pulses for one cycle exactly two cycles after each `red_go`, with `red_sum` valid in that cycle. Requests on consecutive cycles each produce their own result.
- R9: A reduction requested in the same cycle as a broadcast operation returns the accumulator values from before that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 3 | Broadcast operation code |
| op_imm | input | 32 | Immediate operand for the operation |
| rmask_we | input | 1 | Row-mask write strobe |
| rmask_wdata | input | 8 | New row-mask value |
| emask_we | input | 1 | Element-mask row write strobe |
| emask_row | input | 3 | Row whose element mask bits are written |
| emask_wdata | input | 64 | New element mask bits for that row |
| red_go | input | 1 | Start a row reduction |
| red_row | input | 3 | Row to reduce |
| row_mask | output | 8 | Current row-mask register |
| red_sum | output | 40 | Signed row total |
| red_valid | output | 1 | One-cycle pulse marking `red_sum` valid |

## Verification
Two functions can land in the same cycle. The first is a reduction request together with a broadcast update of the row being reduced. The second is a mask write together with an operation that the write would gate. The bench provokes the first case by issuing an add and a reduction of the same row in one cycle. It expects the reduction to return the pre-update total, and a later reduction to return the updated total. It provokes the second case by writing an element mask and issuing an add in one cycle. It then judges, through reductions, that the add reached every column, and that only the next add followed the new mask.

// File: rtl/rowsimd_pkg.sv
package rowsimd_pkg;

  localparam int ACC_W = 32;
  localparam int OPR_W = 8;
  localparam int OP_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 3'd0,
    OP_CLR = 3'd1,
    OP_LDI = 3'd2,
    OP_ADD = 3'd3,
    OP_MAC = 3'd4
  } op_e;

  // True for codes that change an accumulator.
  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return (op == OP_CLR) || (op == OP_LDI) || (op == OP_ADD) || (op == OP_MAC);
  endfunction

  // Signed product of the two low operand bytes, widened to the accumulator.
  function automatic logic [ACC_W-1:0] mac_term(input logic [ACC_W-1:0] imm);
    logic signed [OPR_W-1:0]   a;
    logic signed [OPR_W-1:0]   b;
    logic signed [2*OPR_W-1:0] p;
    a = imm[OPR_W-1:0];
    b = imm[2*OPR_W-1:OPR_W];
    p = a * b;
    return {{(ACC_W-2*OPR_W){p[2*OPR_W-1]}}, p};
  endfunction

  // Next accumulator value for an enabled element.
  function automatic logic [ACC_W-1:0] acc_next(input logic [OP_W-1:0] op,
                                                input logic [ACC_W-1:0] acc,
                                                input logic [ACC_W-1:0] imm);
    case (op)
      OP_CLR:  return '0;
      OP_LDI:  return imm;
      OP_ADD:  return acc + imm;
      OP_MAC:  return acc + mac_term(imm);
      default: return acc;
    endcase
  endfunction

endpackage

// File: rtl/rowsimd_gate.sv
module rowsimd_gate
  import rowsimd_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 64,
  parameter int RSEL_W = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OP_W-1:0]      op_code,
  input  logic                 rmask_we,
  input  logic [ROWS-1:0]      rmask_wdata,
  input  logic                 emask_we,
  input  logic [RSEL_W-1:0]    emask_row,
  input  logic [COLS-1:0]      emask_wdata,
  output logic [ROWS-1:0]      row_mask,
  output logic [ROWS*COLS-1:0] elem_en
);

  logic [ROWS-1:0]            rm_q;
  logic [ROWS-1:0][COLS-1:0]  em_q;
  logic                       act;

  assign act = op_writes(op_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_q <= '1;
    end else if (rmask_we) begin
      rm_q <= rmask_wdata;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        em_q[r] <= '1;
      end else if (emask_we && (emask_row == RSEL_W'(r))) begin
        em_q[r] <= emask_wdata;
      end
    end
    // Row gate and element gate combine; both are the registered values.
    assign elem_en[r*COLS +: COLS] = {COLS{act & rm_q[r]}} & em_q[r];
  end

  assign row_mask = rm_q;

endmodule

// File: rtl/rowsimd_pe.sv
module rowsimd_pe
  import rowsimd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [OP_W-1:0]  op_code,
  input  logic [ACC_W-1:0] op_imm,
  output logic [ACC_W-1:0] acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (en) begin
      acc <= acc_next(op_code, acc, op_imm);
    end
  end

endmodule

// File: rtl/rowsimd_rsum.sv
module rowsimd_rsum
  import rowsimd_pkg::*;
#(
  parameter int COLS   = 64,
  parameter int SUM_W  = 40,
  parameter int GROUPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [COLS*ACC_W-1:0] row_vals,
  output logic [SUM_W-1:0]      sum,
  output logic                  valid
);

  localparam int GSZ = COLS / GROUPS;

  logic [SUM_W-1:0] part_c [GROUPS];
  logic [SUM_W-1:0] part_q [GROUPS];
  logic [SUM_W-1:0] total_c;
  logic             v1_q;

  function automatic logic [SUM_W-1:0] widen(input logic [ACC_W-1:0] v);
    return {{(SUM_W-ACC_W){v[ACC_W-1]}}, v};
  endfunction

  // Stage 1: partial sums of column groups.
  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      part_c[g] = '0;
      for (int k = 0; k < GSZ; k++) begin
        part_c[g] = part_c[g] + widen(row_vals[(g*GSZ+k)*ACC_W +: ACC_W]);
      end
    end
  end

  // Stage 2: add the partials.
  always_comb begin
    total_c = '0;
    for (int g = 0; g < GROUPS; g++) begin
      total_c = total_c + part_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int g = 0; g < GROUPS; g++) part_q[g] <= part_c[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      valid <= 1'b0;
      sum   <= '0;
    end else begin
      v1_q  <= go;
      valid <= v1_q;
      if (v1_q) sum <= total_c;
    end
  end

endmodule

// File: rtl/rowsimd_ctrl.sv
module rowsimd_ctrl
  import rowsimd_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 64,
  parameter int SUM_W  = 40,
  parameter int GROUPS = 8,
  parameter int RSEL_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ACC_W-1:0]  op_imm,
  input  logic              rmask_we,
  input  logic [ROWS-1:0]   rmask_wdata,
  input  logic              emask_we,
  input  logic [RSEL_W-1:0] emask_row,
  input  logic [COLS-1:0]   emask_wdata,
  input  logic              red_go,
  input  logic [RSEL_W-1:0] red_row,
  output logic [ROWS-1:0]   row_mask,
  output logic [SUM_W-1:0]  red_sum,
  output logic              red_valid
);

  localparam int NELEM    = ROWS * COLS;
  localparam int ROW_BITS = COLS * ACC_W;

  logic [NELEM-1:0]       elem_en;
  logic [NELEM*ACC_W-1:0] acc_flat;
  logic [ROW_BITS-1:0]    sel_row;

  rowsimd_gate #(
    .ROWS(ROWS), .COLS(COLS), .RSEL_W(RSEL_W)
  ) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_code     (op_code),
    .rmask_we    (rmask_we),
    .rmask_wdata (rmask_wdata),
    .emask_we    (emask_we),
    .emask_row   (emask_row),
    .emask_wdata (emask_wdata),
    .row_mask    (row_mask),
    .elem_en     (elem_en)
  );

  for (genvar e = 0; e < NELEM; e++) begin : g_pe
    rowsimd_pe u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (elem_en[e]),
      .op_code (op_code),
      .op_imm  (op_imm),
      .acc     (acc_flat[e*ACC_W +: ACC_W])
    );
  end

  assign sel_row = acc_flat[red_row*ROW_BITS +: ROW_BITS];

  rowsimd_rsum #(
    .COLS(COLS), .SUM_W(SUM_W), .GROUPS(GROUPS)
  ) u_rsum (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (red_go),
    .row_vals (sel_row),
    .sum      (red_sum),
    .valid    (red_valid)
  );

endmodule

// File: rtl/rowsimd_chk.sv
module rowsimd_chk
  import rowsimd_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       red_go,
  input logic                       red_valid,
  input logic                       rmask_we,
  input logic [ROWS-1:0]            rmask_wdata,
  input logic [ROWS-1:0]            row_mask,
  input logic [ROWS*COLS-1:0]       elem_en,
  input logic [ROWS*COLS*ACC_W-1:0] acc_flat
);

  localparam int NELEM = ROWS * COLS;

  logic [NELEM*ACC_W-1:0] prev_acc;
  logic [NELEM-1:0]       prev_en;
  logic [NELEM-1:0]       chg;
  logic                   armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      prev_en  <= '0;
      prev_acc <= '0;
    end else begin
      armed    <= 1'b1;
      prev_en  <= elem_en;
      prev_acc <= acc_flat;
    end
  end

  for (genvar e = 0; e < NELEM; e++) begin : g_chg
    assign chg[e] = acc_flat[e*ACC_W +: ACC_W] != prev_acc[e*ACC_W +: ACC_W];
  end

  // R1: row mask comes out of reset with all rows enabled
  a_r1_mask_reset: assert property (@(posedge clk)
    ($past(!rst_n) && rst_n) |-> (row_mask == '1));

  // R3: a row-mask write shows up on the port one cycle later
  a_r3_rmask_write: assert property (@(posedge clk) disable iff (!rst_n)
    rmask_we |=> (row_mask == $past(rmask_wdata)));

  // R5: a gated-off element keeps its accumulator
  a_r5_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((chg & ~prev_en) == '0));

  // R8: each request yields a pulse two cycles later
  a_r8_valid_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    red_go |=> ##1 red_valid);

  // R8: no pulse without a request two cycles earlier
  a_r8_valid_has_go: assert property (@(posedge clk) disable iff (!rst_n)
    red_valid |-> $past(red_go, 2));

endmodule

bind rowsimd_ctrl rowsimd_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .red_go      (red_go),
  .red_valid   (red_valid),
  .rmask_we    (rmask_we),
  .rmask_wdata (rmask_wdata),
  .row_mask    (row_mask),
  .elem_en     (elem_en),
  .acc_flat    (acc_flat)
);

// File: tb/rowsimd_ctrl_test.sv
module rowsimd_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_imm = '0;
  logic        rmask_we = 1'b0;
  logic [7:0]  rmask_wdata = '0;
  logic        emask_we = 1'b0;
  logic [2:0]  emask_row = '0;
  logic [63:0] emask_wdata = '0;
  logic        red_go = 1'b0;
  logic [2:0]  red_row = '0;
  logic [7:0]  row_mask;
  logic [39:0] red_sum;
  logic        red_valid;

  always #5 clk = ~clk;

  rowsimd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_imm(op_imm),
    .rmask_we(rmask_we), .rmask_wdata(rmask_wdata),
    .emask_we(emask_we), .emask_row(emask_row), .emask_wdata(emask_wdata),
    .red_go(red_go), .red_row(red_row),
    .row_mask(row_mask), .red_sum(red_sum), .red_valid(red_valid)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // reference state
  int          m_acc [8][64];
  logic [7:0]  m_rm;
  logic [63:0] m_em [8];

  // scoreboard
  longint exp_q[$];
  int     due_q[$];
  string  tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint row_total(input int r);
    longint s = 0;
    for (int c = 0; c < 64; c++) s += longint'(m_acc[r][c]);
    return s;
  endfunction

  function automatic int apply(input logic [2:0] op, input int a, input logic [31:0] imm);
    int p;
    case (op)
      3'd1: return 0;
      3'd2: return int'(imm);
      3'd3: return a + int'(imm);
      3'd4: begin
        p = int'($signed(imm[7:0])) * int'($signed(imm[15:8]));
        return a + p;
      end
      default: return a;
    endcase
  endfunction

  task automatic step(input logic [2:0] op, input logic [31:0] imm,
                      input logic rwe, input logic [7:0] rd,
                      input logic ewe, input logic [2:0] erow, input logic [63:0] ed,
                      input logic go, input logic [2:0] row, input string tag);
    @(negedge clk);
    op_code = op; op_imm = imm;
    rmask_we = rwe; rmask_wdata = rd;
    emask_we = ewe; emask_row = erow; emask_wdata = ed;
    red_go = go; red_row = row;
    if (go) begin
      exp_q.push_back(row_total(int'(row)));
      due_q.push_back(cyc + 2);
      tag_q.push_back(tag);
    end
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 64; c++)
        if (m_rm[r] && m_em[r][c]) m_acc[r][c] = apply(op, m_acc[r][c], imm);
    if (rwe) m_rm = rd;
    if (ewe) m_em[erow] = ed;
  endtask

  task automatic op1(input logic [2:0] op, input logic [31:0] imm);
    step(op, imm, 1'b0, 8'h0, 1'b0, 3'd0, 64'h0, 1'b0, 3'd0, "");
  endtask

  task automatic red1(input logic [2:0] row, input string tag);
    step(3'd0, 32'h0, 1'b0, 8'h0, 1'b0, 3'd0, 64'h0, 1'b1, row, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(3'd0, 32'h0, 1'b0, 8'h0, 1'b0, 3'd0, 64'h0, 1'b0, 3'd0, "");
  endtask

  task automatic emask_all_on();
    for (int r = 0; r < 8; r++)
      step(3'd0, 32'h0, 1'b0, 8'h0, 1'b1, 3'(r), '1, 1'b0, 3'd0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (red_valid) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R8 unexpected red_valid at cycle %0d: actual=1 expected=0", cyc);
        end else begin
          if (due_q[0] != cyc || $signed(red_sum) != exp_q[0]) begin
            bad++;
            $display("FAIL %s: actual sum=%0d cycle=%0d expected sum=%0d cycle=%0d",
                     tag_q[0], $signed(red_sum), cyc, exp_q[0], due_q[0]);
          end
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
      end else if (exp_q.size() > 0 && due_q[0] <= cyc) begin
        total++; bad++;
        $display("FAIL R8 missing red_valid for %s: actual=0 expected=1 at cycle %0d",
                 tag_q[0], due_q[0]);
        void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  task automatic check_rm(input logic [7:0] exp, input string tag);
    @(negedge clk);
    total++;
    if (row_mask !== exp) begin
      bad++;
      $display("FAIL %s: actual row_mask=%h expected=%h", tag, row_mask, exp);
    end
  endtask

  initial begin
    m_rm = '1;
    for (int r = 0; r < 8; r++) begin
      m_em[r] = '1;
      for (int c = 0; c < 64; c++) m_acc[r][c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_rm(8'hFF, "R1 row mask after reset");
    for (int r = 0; r < 8; r++) red1(3'(r), "R1 R8 accumulators zero after reset, back-to-back");
    idle(3);

    // R2: load and add
    op1(3'd2, 32'd5);
    red1(3'd3, "R2 load immediate");
    // R4 R6: mask write with same-cycle add uses old mask
    step(3'd3, 32'd10, 1'b0, 8'h0, 1'b1, 3'd2, 64'h5555_5555_5555_5555, 1'b0, 3'd0, "");
    red1(3'd2, "R6 same-cycle mask write uses old mask");
    op1(3'd3, 32'd1);
    red1(3'd2, "R4 element mask gates columns");
    red1(3'd1, "R4 other row unaffected by row 2 mask");

    // R3 R5: row mask disables row 2
    step(3'd0, 32'h0, 1'b1, 8'hFB, 1'b0, 3'd0, 64'h0, 1'b0, 3'd0, "");
    check_rm(8'hFB, "R3 row mask write");
    op1(3'd3, 32'd100);
    red1(3'd2, "R5 disabled row keeps values");
    red1(3'd1, "R5 enabled row updated");
    red1(3'd7, "R5 enabled row 7 updated");

    // R2: unused codes change nothing
    op1(3'd5, 32'd9); op1(3'd6, 32'd9); op1(3'd7, 32'd9); op1(3'd0, 32'd9);
    red1(3'd1, "R2 codes 0,5,6,7 leave accumulators");
    red1(3'd2, "R2 codes 0,5,6,7 leave masked row");

    // R9: reduce and add same cycle
    step(3'd3, 32'd7, 1'b0, 8'h0, 1'b0, 3'd0, 64'h0, 1'b1, 3'd0, "R9 reduction sees pre-op values");
    red1(3'd0, "R9 later reduction sees update");

    // R2: clear and MAC with an irregular mask
    step(3'd1, 32'h0, 1'b1, 8'hFF, 1'b1, 3'd4, 64'hF0F0_0000_1234_8001, 1'b0, 3'd0, "");
    op1(3'd4, {16'h0, 8'h80, 8'h80});
    op1(3'd4, {16'hABCD, 8'h07, 8'hFD});
    red1(3'd4, "R2 MAC signed products with mask");
    red1(3'd5, "R2 MAC on fully enabled row");

    // R7: extremes
    emask_all_on();
    op1(3'd2, 32'h7FFF_FFFF);
    red1(3'd3, "R7 max positive row total");
    op1(3'd3, 32'd1);
    red1(3'd6, "R2 R7 add wraps to most negative");
    op1(3'd2, 32'h8000_0000);
    red1(3'd0, "R7 most negative row total");
    op1(3'd1, 32'h0);
    red1(3'd0, "R2 clear");

    idle(4);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R8 results outstanding: actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule